// File: doc/BRIEF.md
# Typed Vectored Interrupt Controller

This block gathers service requests from four serial channels and turns them into one host interrupt line with a vector byte. Each channel raises four kinds of request: a receive exception (a frame with errors), good receive data, a transmit FIFO request and a modem-signal or timer change. The host programs a separate vector for every pairing of request kind and channel. The good-data class has its own vector, so a handler can jump straight to a data-transfer routine without reading any status.

FIFO requests come from watching the occupancy level of each channel's 16-entry receive and transmit FIFO. A receive request fires when the level rises from below a programmable threshold to at or above it. A transmit request fires when the level falls from above its threshold to at or below it. A per-channel, per-direction mode decides where such a request goes. In DMA mode it is dropped here, because the DMA engine serves it. In interrupt mode it becomes a pending interrupt. In polled mode it sets a status bit and raises no interrupt. Exceptions and modem/timer changes always interrupt.

The host sees `irq` while anything is pending. A one-cycle `ack` pulse returns the vector of the highest-priority pending source and retires that source.

Top module: `tvirq_top`

## Requirements
- R1: With a channel's receive mode at interrupt (code 01), the channel's good-data source becomes pending when its receive level goes from below the receive threshold in one cycle to at or above it in the next. `irq` is high one cycle after the crossing level is sampled.
- R2: With a channel's transmit mode at interrupt (code 01), the channel's transmit source becomes pending when its transmit level goes from above the transmit threshold to at or below it.
- R3: A pulse on `rx_err_req[c]` or `mdm_req[c]` makes the matching source pending whatever the channel's modes are.
- R4: In DMA mode (code 00), and under the reserved code 11, a FIFO threshold crossing changes neither `irq` nor `poll_status`.
- R5: In polled mode (code 10), a crossing sets `poll_status` bit c for receive or bit 4+c for transmit, and leaves `irq` low. A bit stays set until a write to address 24 with a 1 in that bit position.
- R6: Sources are ranked by index type*4+channel, the lowest index first. The types are numbered receive exception 0, good receive 1, transmit 2 and modem/timer 3.
- R7: `irq` is high exactly while some source is pending. It stays high until acknowledged, and an `ack` while `irq` is low has no effect.
- R8: An `ack` sampled while `irq` is high drives `vec_valid` high in the next cycle, with `vec_out` equal to the programmed vector of the winning source, and retires that source. `vec_out` is 0 whenever `vec_valid` is low.
- R9: A request that arrives in the same cycle as an acknowledge stays pending, including a new request from the source being retired.
- R10: Register writes take effect for events sampled from the next cycle on. Addresses 0 to 15 hold the vector for source index type*4+channel. Addresses 16+c hold the channel mode, with receive mode in bits [1:0] and transmit mode in bits [3:2]. Addresses 20+c hold the thresholds, receive in bits [3:0] and transmit in bits [7:4]. Addresses 25 to 31 are ignored.
- R11: After reset, `irq`, `vec_valid`, `vec_out` and `poll_status` are 0, all modes are DMA, and all vectors and thresholds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| rx_level | input | 20 | Receive FIFO occupancy, 5 bits per channel, channel 0 in the low bits |
| tx_level | input | 20 | Transmit FIFO occupancy, 5 bits per channel |
| rx_err_req | input | 4 | Receive exception pulse per channel |
| mdm_req | input | 4 | Modem-signal/timer change pulse per channel |
| ack | input | 1 | Host acknowledge pulse |
| irq | output | 1 | Interrupt request to the host |
| vec_valid | output | 1 | Vector valid, one cycle per accepted acknowledge |
| vec_out | output | 8 | Vector of the acknowledged source |
| poll_status | output | 8 | Polled-mode request flags: receive in [3:0], transmit in [7:4] |

## Verification
Every result appears one clock edge after its cause. A request or level crossing sampled at an edge shows up on `irq` or `poll_status` right after that edge. An `ack` sampled at an edge puts the vector on `vec_out` after that same edge. A register write affects only events sampled at later edges. The bench drives inputs just after the falling edge and updates its own model across the rising edge that follows. It compares every output at the next falling edge, so each check falls exactly one cycle after the stimulus that causes it. Directed phases cover threshold crossings in each mode, priority order and acknowledges that coincide with new requests, and a long random phase then mixes writes, levels, pulses and acknowledges.

// File: rtl/tvirq_pkg.sv
package tvirq_pkg;

    localparam int TV_NCH      = 4;
    localparam int TV_NTYPE    = 4;
    localparam int TV_DEPTH    = 16;
    localparam int TV_VEC_W    = 8;

    // transfer mode per channel and direction
    typedef enum logic [1:0] {
        MODE_DMA  = 2'b00,
        MODE_INT  = 2'b01,
        MODE_POLL = 2'b10,
        MODE_RSV  = 2'b11
    } xfer_mode_e;

    // request kinds, numbered in priority order (0 served first)
    typedef enum logic [1:0] {
        SRC_RXERR  = 2'd0,
        SRC_RXGOOD = 2'd1,
        SRC_TX     = 2'd2,
        SRC_MDM    = 2'd3
    } src_type_e;

    typedef struct packed {
        xfer_mode_e tx_mode;
        xfer_mode_e rx_mode;
    } chan_mode_t;

    function automatic int src_index(src_type_e t, int ch, int nch);
        return int'(t) * nch + ch;
    endfunction

    function automatic logic raises_irq(xfer_mode_e m);
        return m == MODE_INT;
    endfunction

    function automatic logic raises_poll(xfer_mode_e m);
        return m == MODE_POLL;
    endfunction

endpackage

// File: rtl/tvirq_regs.sv
module tvirq_regs
    import tvirq_pkg::*;
#(
    parameter int NCH    = TV_NCH,
    parameter int VEC_W  = TV_VEC_W,
    parameter int THR_W  = 4,
    parameter int NSRC   = TV_NTYPE * NCH,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VEC_W-1:0]  wdata,
    output logic [VEC_W-1:0]  vec_tab  [NSRC],
    output chan_mode_t        mode_tab [NCH],
    output logic [THR_W-1:0]  rx_thr   [NCH],
    output logic [THR_W-1:0]  tx_thr   [NCH],
    output logic [2*NCH-1:0]  poll_clr
);

    localparam int MODE_BASE = NSRC;
    localparam int THR_BASE  = NSRC + NCH;
    localparam int CLR_ADDR  = NSRC + 2 * NCH;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSRC; i++) vec_tab[i] <= '0;
            for (int c = 0; c < NCH; c++) begin
                mode_tab[c] <= '{tx_mode: MODE_DMA, rx_mode: MODE_DMA};
                rx_thr[c]   <= '0;
                tx_thr[c]   <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < NSRC; i++)
                if (addr == ADDR_W'(i)) vec_tab[i] <= wdata;
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_W'(MODE_BASE + c)) begin
                    mode_tab[c].rx_mode <= xfer_mode_e'(wdata[1:0]);
                    mode_tab[c].tx_mode <= xfer_mode_e'(wdata[3:2]);
                end
                if (addr == ADDR_W'(THR_BASE + c)) begin
                    rx_thr[c] <= wdata[THR_W-1:0];
                    tx_thr[c] <= wdata[2*THR_W-1:THR_W];
                end
            end
        end
    end

    // write-one-to-clear strobe for the polled flags
    assign poll_clr = (we && addr == ADDR_W'(CLR_ADDR)) ? wdata[2*NCH-1:0] : '0;

endmodule

// File: rtl/tvirq_detect.sv
module tvirq_detect #(
    parameter int NCH   = 4,
    parameter int LVL_W = 5,
    parameter int THR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH*LVL_W-1:0] rx_level,
    input  logic [NCH*LVL_W-1:0] tx_level,
    input  logic [THR_W-1:0]   rx_thr [NCH],
    input  logic [THR_W-1:0]   tx_thr [NCH],
    output logic [NCH-1:0]     rx_cross,
    output logic [NCH-1:0]     tx_cross
);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            logic [LVL_W-1:0] rx_prev, tx_prev;
            logic [LVL_W-1:0] rx_now, tx_now;
            logic [LVL_W-1:0] rx_lim, tx_lim;

            assign rx_now = rx_level[c*LVL_W +: LVL_W];
            assign tx_now = tx_level[c*LVL_W +: LVL_W];
            assign rx_lim = {{(LVL_W-THR_W){1'b0}}, rx_thr[c]};
            assign tx_lim = {{(LVL_W-THR_W){1'b0}}, tx_thr[c]};

            always_ff @(posedge clk) begin
                if (rst) begin
                    rx_prev <= '0;
                    tx_prev <= '0;
                end else begin
                    rx_prev <= rx_now;
                    tx_prev <= tx_now;
                end
            end

            // receive fills upward past the mark, transmit drains downward past it
            assign rx_cross[c] = (rx_prev < rx_lim) && (rx_now >= rx_lim);
            assign tx_cross[c] = (tx_prev > tx_lim) && (tx_now <= tx_lim);
        end
    endgenerate

endmodule

// File: rtl/tvirq_arb.sv
module tvirq_arb #(
    parameter int NSRC  = 16,
    parameter int IDX_W = 4
) (
    input  logic [NSRC-1:0]  pend,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx,
    output logic [NSRC-1:0]  win_onehot
);

    always_comb begin
        win_idx    = '0;
        win_onehot = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_idx    = IDX_W'(i);
                win_onehot = NSRC'(1) << i;
            end
        end
    end

    assign win_valid = |pend;

endmodule

// File: rtl/tvirq_pending.sv
module tvirq_pending
    import tvirq_pkg::*;
#(
    parameter int NCH  = TV_NCH,
    parameter int NSRC = TV_NTYPE * NCH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  rx_cross,
    input  logic [NCH-1:0]  tx_cross,
    input  logic [NCH-1:0]  rx_err,
    input  logic [NCH-1:0]  mdm,
    input  chan_mode_t      mode_tab [NCH],
    input  logic [2*NCH-1:0] poll_clr,
    input  logic            ack_fire,
    input  logic [NSRC-1:0] win_onehot,
    output logic [NSRC-1:0] pend_q,
    output logic [2*NCH-1:0] poll_q
);

    logic [NSRC-1:0]  set_vec;
    logic [2*NCH-1:0] poll_set;
    logic [NSRC-1:0]  retire;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_route
            assign set_vec[src_index(SRC_RXERR,  c, NCH)] = rx_err[c];
            assign set_vec[src_index(SRC_RXGOOD, c, NCH)] = rx_cross[c] && raises_irq(mode_tab[c].rx_mode);
            assign set_vec[src_index(SRC_TX,     c, NCH)] = tx_cross[c] && raises_irq(mode_tab[c].tx_mode);
            assign set_vec[src_index(SRC_MDM,    c, NCH)] = mdm[c];
            assign poll_set[c]       = rx_cross[c] && raises_poll(mode_tab[c].rx_mode);
            assign poll_set[NCH + c] = tx_cross[c] && raises_poll(mode_tab[c].tx_mode);
        end
    endgenerate

    assign retire = ack_fire ? win_onehot : '0;

    // clear first, then set: a fresh request always survives
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            poll_q <= '0;
        end else begin
            pend_q <= (pend_q & ~retire) | set_vec;
            poll_q <= (poll_q & ~poll_clr) | poll_set;
        end
    end

    AST_NEW_REQ_KEPT: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R9

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && ((set_vec & win_onehot) == '0)) |=> ((pend_q & $past(win_onehot)) == '0)); // R8

    AST_POLL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (poll_q != '0) |=> ((poll_q & $past(poll_q & ~poll_clr)) == $past(poll_q & ~poll_clr))); // R5

endmodule

// File: rtl/tvirq_top.sv
module tvirq_top
    import tvirq_pkg::*;
#(
    parameter int NCH        = TV_NCH,
    parameter int FIFO_DEPTH = TV_DEPTH,
    parameter int VEC_W      = TV_VEC_W,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
    parameter int THR_W      = $clog2(FIFO_DEPTH),
    parameter int NSRC       = TV_NTYPE * NCH,
    parameter int IDX_W      = $clog2(NSRC),
    parameter int ADDR_W     = $clog2(NSRC + 2 * NCH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [VEC_W-1:0]     cfg_wdata,
    input  logic [NCH*LVL_W-1:0] rx_level,
    input  logic [NCH*LVL_W-1:0] tx_level,
    input  logic [NCH-1:0]       rx_err_req,
    input  logic [NCH-1:0]       mdm_req,
    input  logic                 ack,
    output logic                 irq,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_out,
    output logic [2*NCH-1:0]     poll_status
);

    logic [VEC_W-1:0] vec_tab  [NSRC];
    chan_mode_t       mode_tab [NCH];
    logic [THR_W-1:0] rx_thr   [NCH];
    logic [THR_W-1:0] tx_thr   [NCH];
    logic [2*NCH-1:0] poll_clr;
    logic [NCH-1:0]   rx_cross, tx_cross;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  win_onehot;
    logic [IDX_W-1:0] win_idx;
    logic             win_valid;
    logic             ack_fire;

    tvirq_regs #(
        .NCH(NCH), .VEC_W(VEC_W), .THR_W(THR_W), .NSRC(NSRC), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .vec_tab(vec_tab), .mode_tab(mode_tab), .rx_thr(rx_thr), .tx_thr(tx_thr),
        .poll_clr(poll_clr)
    );

    tvirq_detect #(
        .NCH(NCH), .LVL_W(LVL_W), .THR_W(THR_W)
    ) detect_i (
        .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
        .rx_thr(rx_thr), .tx_thr(tx_thr), .rx_cross(rx_cross), .tx_cross(tx_cross)
    );

    tvirq_pending #(
        .NCH(NCH), .NSRC(NSRC)
    ) pending_i (
        .clk(clk), .rst(rst), .rx_cross(rx_cross), .tx_cross(tx_cross),
        .rx_err(rx_err_req), .mdm(mdm_req), .mode_tab(mode_tab),
        .poll_clr(poll_clr), .ack_fire(ack_fire), .win_onehot(win_onehot),
        .pend_q(pend), .poll_q(poll_status)
    );

    tvirq_arb #(
        .NSRC(NSRC), .IDX_W(IDX_W)
    ) arb_i (
        .pend(pend), .win_valid(win_valid), .win_idx(win_idx), .win_onehot(win_onehot)
    );

    assign irq      = win_valid;
    assign ack_fire = ack && win_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= ack_fire;
            vec_out   <= ack_fire ? vec_tab[win_idx] : '0;
        end
    end

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq); // R7

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack)); // R8

    AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (pend[win_idx] && ((pend & ~({NSRC{1'b1}} << win_idx)) == '0))); // R6

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec_out == '0)); // R8

endmodule

// File: tb/tvirq_top_tb.sv
module tvirq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NSRC = 16;
    localparam int LVL_W = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [19:0] rx_level = '0;
    logic [19:0] tx_level = '0;
    logic [3:0]  rx_err_req = '0;
    logic [3:0]  mdm_req = '0;
    logic        ack = 1'b0;
    logic        irq, vec_valid;
    logic [7:0]  vec_out, poll_status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    logic [7:0]  m_vec [NSRC];
    int          m_rxm [NCH], m_txm [NCH], m_rxt [NCH], m_txt [NCH];
    int          m_prx [NCH], m_ptx [NCH];
    logic [15:0] m_pend;
    logic [7:0]  m_poll;
    logic        m_vv;
    logic [7:0]  m_vo;

    always #(CLK_PERIOD/2) clk = ~clk;

    tvirq_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_level(rx_level), .tx_level(tx_level), .rx_err_req(rx_err_req), .mdm_req(mdm_req),
        .ack(ack), .irq(irq), .vec_valid(vec_valid), .vec_out(vec_out), .poll_status(poll_status)
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int first_pending(logic [15:0] p);
        for (int i = 0; i < NSRC; i++) if (p[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NSRC; i++) m_vec[i] = '0;
        for (int c = 0; c < NCH; c++) begin
            m_rxm[c] = 0; m_txm[c] = 0; m_rxt[c] = 0; m_txt[c] = 0;
            m_prx[c] = 0; m_ptx[c] = 0;
        end
        m_pend = '0; m_poll = '0; m_vv = 0; m_vo = '0;
    endtask

    task automatic model_advance();
        int win;
        logic [15:0] set;
        logic [7:0]  pset;
        logic [7:0]  clr;
        win = first_pending(m_pend);
        set = '0; pset = '0;
        for (int c = 0; c < NCH; c++) begin
            int rl, tl;
            bit rc, tc;
            rl = int'(rx_level[c*LVL_W +: LVL_W]);
            tl = int'(tx_level[c*LVL_W +: LVL_W]);
            rc = (m_prx[c] < m_rxt[c]) && (rl >= m_rxt[c]);
            tc = (m_ptx[c] > m_txt[c]) && (tl <= m_txt[c]);
            set[c]      = rx_err_req[c];
            set[4 + c]  = rc && (m_rxm[c] == 1);
            set[8 + c]  = tc && (m_txm[c] == 1);
            set[12 + c] = mdm_req[c];
            pset[c]     = rc && (m_rxm[c] == 2);
            pset[4 + c] = tc && (m_txm[c] == 2);
            m_prx[c] = rl;
            m_ptx[c] = tl;
        end
        m_vv = ack && (win >= 0);
        m_vo = m_vv ? m_vec[win] : 8'h00;
        if (m_vv) m_pend[win] = 1'b0;
        m_pend = m_pend | set;
        clr = (cfg_we && cfg_addr == 5'd24) ? cfg_wdata : 8'h00;
        m_poll = (m_poll & ~clr) | pset;
        if (cfg_we) begin
            int a;
            a = int'(cfg_addr);
            if (a < 16) m_vec[a] = cfg_wdata;
            else if (a < 20) begin
                m_rxm[a-16] = int'(cfg_wdata[1:0]);
                m_txm[a-16] = int'(cfg_wdata[3:2]);
            end else if (a < 24) begin
                m_rxt[a-20] = int'(cfg_wdata[3:0]);
                m_txt[a-20] = int'(cfg_wdata[7:4]);
            end
        end
    endtask

    // inputs are already driven (after a falling edge); run one cycle and compare
    task automatic step(string tag);
        model_advance();
        @(posedge clk);
        @(negedge clk);
        check(tag, "irq", 16'(irq), 16'(m_pend != '0));
        check(tag, "vec_valid", 16'(vec_valid), 16'(m_vv));
        check(tag, "vec_out", 16'(vec_out), 16'(m_vo));
        check(tag, "poll_status", 16'(poll_status), 16'(m_poll));
        cfg_we = 0; ack = 0; rx_err_req = '0; mdm_req = '0;
    endtask

    task automatic wr(string tag, int a, int d);
        cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        step(tag);
    endtask

    task automatic set_rx(int c, int v); rx_level[c*LVL_W +: LVL_W] = 5'(v); endtask
    task automatic set_tx(int c, int v); tx_level[c*LVL_W +: LVL_W] = 5'(v); endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11: reset state
        check("R11", "irq", 16'(irq), 16'h0);
        check("R11", "vec_valid", 16'(vec_valid), 16'h0);
        check("R11", "vec_out", 16'(vec_out), 16'h0);
        check("R11", "poll_status", 16'(poll_status), 16'h0);

        // R10: distinct vectors, modes and thresholds
        for (int i = 0; i < NSRC; i++) wr("R10", i, 8'h91 + i * 7);
        wr("R10", 16, 8'h05);   // ch0: rx int, tx int
        wr("R10", 17, 8'h0A);   // ch1: polled both
        wr("R10", 18, 8'h00);   // ch2: DMA both
        wr("R10", 19, 8'h0F);   // ch3: reserved code both
        for (int c = 0; c < NCH; c++) wr("R10", 20 + c, 8'h48);
        wr("R10", 27, 8'hFF);   // unused address
        ack = 1; step("R7");    // ack with nothing pending

        // R1: receive crossing on ch0
        set_rx(0, 7); step("R1");
        set_rx(0, 8); step("R1");
        set_rx(0, 12); step("R1"); // staying above: no new request
        ack = 1; step("R8");
        step("R8");

        // R2: transmit drain on ch0
        set_tx(0, 9); step("R2");
        set_tx(0, 4); step("R2");
        ack = 1; step("R8");

        // R5: polled ch1
        set_rx(1, 12); set_tx(1, 10); step("R5");
        set_tx(1, 0); step("R5");
        step("R5");
        wr("R5", 24, 8'h02);
        wr("R5", 24, 8'h10);

        // R4: DMA and reserved channels
        set_rx(2, 16); set_rx(3, 9); set_tx(2, 11); set_tx(3, 13); step("R4");
        set_tx(2, 1); set_tx(3, 2); step("R4");

        // R3: exceptions and modem changes regardless of mode
        rx_err_req = 4'b1000; mdm_req = 4'b0100; step("R3");

        // R6: several pending, served lowest index first
        set_rx(0, 0); step("R6");
        set_rx(0, 15); rx_err_req = 4'b0100; mdm_req = 4'b0001; step("R6");
        for (int k = 0; k < 6; k++) begin ack = 1; step("R6"); end

        // R7: held without ack
        mdm_req = 4'b0010; step("R7");
        for (int k = 0; k < 4; k++) step("R7");
        ack = 1; step("R7");

        // R9: same source re-requests during its own ack
        rx_err_req = 4'b0001; step("R9");
        ack = 1; rx_err_req = 4'b0001; step("R9");
        ack = 1; mdm_req = 4'b1000; step("R9");
        ack = 1; step("R9");
        ack = 1; step("R9");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 9) == 0) begin
                cfg_we = 1;
                cfg_addr = 5'($urandom_range(0, 31));
                cfg_wdata = 8'($urandom_range(0, 255));
            end
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(0, 2) == 0) set_rx(c, $urandom_range(0, 16));
                if ($urandom_range(0, 2) == 0) set_tx(c, $urandom_range(0, 16));
                rx_err_req[c] = ($urandom_range(0, 19) == 0);
                mdm_req[c]    = ($urandom_range(0, 19) == 0);
            end
            ack = ($urandom_range(0, 2) == 0);
            step("R8");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule